// File: doc/BRIEF.md
# Mixed-Capability Three-Port Register File

A 32-bit register file with two combinational read ports and one write port, all usable in the same cycle. Its rows are grouped into capability classes, and each class has its own write granularity. Lane rows take writes to the low byte, the second byte, the low half or the whole word. Half rows take only low-half or whole-word writes. Word rows take only whole-word writes. One shadow row, the last one, can also load a copy of the row just below it without using any port.

Selectors are 7 bits wide. On the read side, selectors with the top bit set return constants. A read always returns the full 32-bit word. Picking out a byte or a half, and any bit interleaving, is left to downstream logic. A write whose width the target row does not support is dropped, and a combinational error flag is raised for that cycle.

Row order with default parameters:

| Rows | Class |
|------|-------|
| 0 to 3 | lane rows |
| 4 to 6 | word rows |
| 7 to 10 | half rows |
| 11 | shadow row, which copies row 10 |

Top module: `mixed_regfile`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every row to zero, and any write requested during that cycle is lost.
- R2: Both read ports return the full 32-bit content of their selected rows combinationally, while a write takes effect at the rising edge. A port that reads the row being written in the same cycle sees the old value.
- R3: The write size is encoded as follows: `00` writes bits 7:0, `01` writes bits 15:8, `10` writes bits 15:0 and `11` writes bits 31:0, with data taken from the same bit positions of `wr_data`. Lane rows 0 to 3 accept all four sizes, and bits outside the written lanes keep their value.
- R4: Word rows 4 to 6 accept only size `11`, and any other size leaves the row unchanged.
- R5: Half rows 7 to 10 accept sizes `10` and `11`, and sizes `00` and `01` leave the row unchanged.
- R6: Shadow row 11 accepts only size `11`. When `copy_en` is high at an edge, row 11 loads the value that row 10 held before that edge, even if row 10 is being written in the same cycle.
- R7: If `copy_en` and an accepted write to row 11 occur in the same cycle, the port write wins. If the write to row 11 is rejected, the copy still takes place.
- R8: Read port B returns zero when it selects row 11, and read port A returns the row's content.
- R9: A read selector with bit 6 set returns a constant: `7'h7F` gives all ones, and any other such selector gives its low 6 bits zero-extended. Selectors 12 to 63 return zero.
- R10: `wr_err` is high in the cycle in which `wr_en` is high and either the size is unsupported by the target row or the selector has bit 6 set or is 12 or more. Such writes change no row, and `wr_err` is never high while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 7 | Read port A selector |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 7 | Read port B selector |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_sel | input | 7 | Write row selector |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, lane-aligned |
| copy_en | input | 1 | Copy row 10 into row 11 |
| wr_err | output | 1 | Rejected write in this cycle |

## Verification
The bench builds the block with its default counts: four lane rows, three word rows, four half rows and the shadow row. With those values every class boundary is reachable with short selectors, and so is the copy source sitting directly under the shadow row. Directed sequences hit each size against each class, and they also cover the copy colliding with writes to the source row and to the shadow row. A random phase follows that mixes out-of-range selectors, constant codes and same-cycle read-after-write. A behavioural model is compared against both read ports and the error flag on every clock.

// File: rtl/mrf_pkg.sv
// Package: shared types and helpers for the mixed-capability register file.
// Assumes a 32-bit word split into three write lanes: [7:0], [15:8], [31:16].
package mrf_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 3;

    // Write size codes carried on wr_size.
    typedef enum logic [1:0] {
        SZ_LO8  = 2'b00,
        SZ_HI8  = 2'b01,
        SZ_H16  = 2'b10,
        SZ_W32  = 2'b11
    } wsize_e;

    // Capability class of a row.
    typedef enum logic [1:0] {
        RC_LANE,
        RC_WORD,
        RC_HALF,
        RC_SHADOW
    } rclass_e;

    // Lane enable pattern for a size code (bit0 = [7:0], bit1 = [15:8], bit2 = upper half).
    function automatic logic [LANES-1:0] lane_mask(wsize_e s);
        case (s)
            SZ_LO8:  return 3'b001;
            SZ_HI8:  return 3'b010;
            SZ_H16:  return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    // Whether a row class accepts a size code.
    function automatic logic size_ok(rclass_e c, wsize_e s);
        case (c)
            RC_LANE: return 1'b1;
            RC_HALF: return (s == SZ_H16) || (s == SZ_W32);
            default: return (s == SZ_W32);
        endcase
    endfunction

    // Class of row r: lane rows, then word rows, then half rows, then the shadow row.
    function automatic rclass_e row_class(int r, int n_lane, int n_word, int n_half);
        if (r < n_lane)                       return RC_LANE;
        else if (r < n_lane + n_word)         return RC_WORD;
        else if (r < n_lane + n_word + n_half) return RC_HALF;
        else                                  return RC_SHADOW;
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
// Module: rf_write_decode
// Turns a write request into per-row lane enables, honouring each row's class.
// Assumes rows are ordered lane, word, half, shadow; flags any rejected request.
module rf_write_decode
    import mrf_pkg::*;
#(
    parameter int N_LANE = 4,
    parameter int N_WORD = 3,
    parameter int N_HALF = 4,
    parameter int SEL_W  = 7,
    localparam int NROWS = N_LANE + N_WORD + N_HALF + 1
) (
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [1:0]                  wr_size,
    output logic [NROWS-1:0][LANES-1:0] lane_we,
    output logic                        wr_err
);

    wsize_e size_q;
    logic   accepted;

    assign size_q = wsize_e'(wr_size);

    // Per-row lane enables and overall acceptance of the request.
    always_comb begin
        accepted = 1'b0;
        for (int r = 0; r < NROWS; r++) begin
            lane_we[r] = '0;
            if (wr_en && (wr_sel == SEL_W'(r)) &&
                size_ok(row_class(r, N_LANE, N_WORD, N_HALF), size_q)) begin
                lane_we[r] = lane_mask(size_q);
                accepted   = 1'b1;
            end
        end
    end

    // Error whenever a request was made and no row took it.
    assign wr_err = wr_en && !accepted;

endmodule

// File: rtl/rf_row.sv
// Module: rf_row
// One 32-bit storage row with three lane write enables and a copy load.
// Assumes a port write (any lane enabled) has priority over the copy load.
module rf_row
    import mrf_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copy_en,
    input  logic [DATA_W-1:0] copy_data,
    output logic [DATA_W-1:0] q
);

    localparam int HI_LO = 2 * BYTE_W;

    // Row state: reset, lane-wise port write, else copy load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (|lane_we) begin
            if (lane_we[0]) q[BYTE_W-1:0]        <= wr_data[BYTE_W-1:0];
            if (lane_we[1]) q[HI_LO-1:BYTE_W]    <= wr_data[HI_LO-1:BYTE_W];
            if (lane_we[2]) q[DATA_W-1:HI_LO]    <= wr_data[DATA_W-1:HI_LO];
        end else if (copy_en) begin
            q <= copy_data;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// Combinational read selector with a constant space and an optional hidden row.
// Assumes selector top bit picks constants; HIDE_ROW < 0 means no hidden row.
module rf_read_port #(
    parameter int NROWS    = 12,
    parameter int DATA_W   = 32,
    parameter int SEL_W    = 7,
    parameter int HIDE_ROW = -1
) (
    input  logic [SEL_W-1:0]              sel,
    input  logic [NROWS-1:0][DATA_W-1:0]  rows,
    output logic [DATA_W-1:0]             data
);

    localparam int LOW_W = SEL_W - 1;

    logic [LOW_W-1:0] low;
    assign low = sel[LOW_W-1:0];

    // Select constant, row content, or zero for unmapped or hidden rows.
    always_comb begin
        data = '0;
        if (sel[SEL_W-1]) begin
            data = (low == '1) ? '1 : DATA_W'(low);
        end else begin
            for (int r = 0; r < NROWS; r++) begin
                if ((sel == SEL_W'(r)) && (r != HIDE_ROW)) data = rows[r];
            end
        end
    end

endmodule

// File: rtl/mixed_regfile.sv
// Module: mixed_regfile (top)
// Three-port register file whose rows have class-specific write widths, plus a
// shadow row that copies the row below it. Assumes lane-aligned write data.
module mixed_regfile
    import mrf_pkg::*;
#(
    parameter int N_LANE = 4,
    parameter int N_WORD = 3,
    parameter int N_HALF = 4,
    parameter int SEL_W  = 7,
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copy_en,
    output logic              wr_err
);

    localparam int NROWS    = N_LANE + N_WORD + N_HALF + 1;
    localparam int SHADOW   = NROWS - 1;
    localparam int COPY_SRC = NROWS - 2;

    logic [NROWS-1:0][LANES-1:0]  lane_we;
    logic [NROWS-1:0][DATA_W-1:0] row_q;

    rf_write_decode #(
        .N_LANE(N_LANE), .N_WORD(N_WORD), .N_HALF(N_HALF), .SEL_W(SEL_W)
    ) dec_i (
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
        .lane_we(lane_we), .wr_err(wr_err)
    );

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        if (r == SHADOW) begin : g_shadow
            rf_row #(.DATA_W(DATA_W)) row_i (
                .clk(clk), .rst_n(rst_n), .lane_we(lane_we[r]), .wr_data(wr_data),
                .copy_en(copy_en), .copy_data(row_q[COPY_SRC]), .q(row_q[r])
            );
        end else begin : g_plain
            rf_row #(.DATA_W(DATA_W)) row_i (
                .clk(clk), .rst_n(rst_n), .lane_we(lane_we[r]), .wr_data(wr_data),
                .copy_en(1'b0), .copy_data({DATA_W{1'b0}}), .q(row_q[r])
            );
        end
    end

    rf_read_port #(
        .NROWS(NROWS), .DATA_W(DATA_W), .SEL_W(SEL_W), .HIDE_ROW(-1)
    ) rda_i (
        .sel(rd_a_sel), .rows(row_q), .data(rd_a_data)
    );

    rf_read_port #(
        .NROWS(NROWS), .DATA_W(DATA_W), .SEL_W(SEL_W), .HIDE_ROW(SHADOW)
    ) rdb_i (
        .sel(rd_b_sel), .rows(row_q), .data(rd_b_data)
    );

endmodule

// File: rtl/mixed_regfile_chk.sv
// Module: mixed_regfile_chk
// Port-level properties of mixed_regfile, bound into every instance.
module mixed_regfile_chk #(
    parameter int NROWS     = 12,
    parameter int HALF_BASE = 7,
    parameter int SEL_W     = 7,
    parameter int DATA_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  rd_a_sel,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [SEL_W-1:0]  rd_b_sel,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [1:0]        wr_size,
    input logic              copy_en,
    input logic              wr_err
);

    logic alive;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) alive <= 1'b0;
        else        alive <= 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_a_sel[SEL_W-1] || rd_a_data == '0));

    // R2
    read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alive && $past(!wr_en && !copy_en) && $stable(rd_a_sel) |-> $stable(rd_a_data));

    // R5
    half_byte_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == SEL_W'(HALF_BASE) && !wr_size[1] |-> wr_err);

    // R8
    portb_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_sel == SEL_W'(NROWS - 1) |-> rd_b_data == '0);

    // R9
    const_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_sel == '1 |-> rd_a_data == '1);

    // R10
    err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err);

endmodule

bind mixed_regfile mixed_regfile_chk #(
    .NROWS(NROWS), .HALF_BASE(N_LANE + N_WORD), .SEL_W(SEL_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_size(wr_size), .copy_en(copy_en), .wr_err(wr_err)
);

// File: tb/mixed_regfile_tb_top.sv
// Bench: behavioural model of the register file compared every clock.
module mixed_regfile_tb_top;

    localparam int NR = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, copy_en = 1'b0, wr_err;
    logic [1:0]  wr_size = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] mem [NR];

    always #4 clk = ~clk;

    mixed_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_size(wr_size), .wr_data(wr_data), .copy_en(copy_en), .wr_err(wr_err)
    );

    function automatic bit m_ok(logic [6:0] s, logic [1:0] z);
        if (s[6] || s >= 7'(NR)) return 0;
        if (s < 4) return 1;
        if (s < 7) return z == 2'b11;
        if (s < 11) return z[1];
        return z == 2'b11;
    endfunction

    function automatic logic [31:0] m_read(logic [6:0] s, bit portb);
        if (s[6]) return (s[5:0] == 6'h3F) ? 32'hFFFF_FFFF : {26'd0, s[5:0]};
        if (s >= 7'(NR)) return 32'd0;
        if (portb && s == 7'd11) return 32'd0;
        return mem[s[3:0]];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // One clock: drive, check combinational outputs, then update the model.
    task automatic cyc(string tag, bit we, logic [6:0] ws, logic [1:0] sz,
                       logic [31:0] wd, bit cp, logic [6:0] ra, logic [6:0] rb);
        logic [31:0] old10, nv;
        bit          ok;
        @(negedge clk);
        wr_en = we; wr_sel = ws; wr_size = sz; wr_data = wd;
        copy_en = cp; rd_a_sel = ra; rd_b_sel = rb;
        #1;
        chk(tag, "rd_a", rd_a_data, m_read(ra, 0));
        chk(tag, "rd_b", rd_b_data, m_read(rb, 1));
        chk(tag, "wr_err", {31'd0, wr_err}, {31'd0, we && !m_ok(ws, sz)});
        @(posedge clk);
        old10 = mem[10];
        ok = we && m_ok(ws, sz);
        if (ok) begin
            nv = mem[ws[3:0]];
            case (sz)
                2'b00: nv[7:0]  = wd[7:0];
                2'b01: nv[15:8] = wd[15:8];
                2'b10: nv[15:0] = wd[15:0];
                default: nv = wd;
            endcase
            mem[ws[3:0]] = nv;
        end
        if (cp && !(ok && ws == 7'd11)) mem[11] = old10;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b1; wr_sel = 7'd0; wr_size = 2'b11;
        wr_data = 32'hDEAD_BEEF; copy_en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < NR; i++) mem[i] = '0;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0; copy_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: every row reads zero after reset
        for (int i = 0; i < NR; i++) cyc("R1", 0, 0, 0, 0, 0, 7'(i), 7'd0);

        // R2: same-cycle write and read of one row returns old value
        cyc("R2", 1, 7'd1, 2'b11, 32'hCAFE_0001, 0, 7'd1, 7'd1);
        cyc("R2", 1, 7'd2, 2'b11, 32'h1234_5678, 0, 7'd1, 7'd1);
        cyc("R2", 0, 0, 0, 0, 0, 7'd1, 7'd2);

        // R3: lane row sizes
        cyc("R3", 1, 7'd0, 2'b11, 32'h1122_3344, 0, 7'd0, 7'd0);
        cyc("R3", 1, 7'd0, 2'b00, 32'hAAAA_AA55, 0, 7'd0, 7'd0);
        cyc("R3", 1, 7'd0, 2'b01, 32'hBBBB_66BB, 0, 7'd0, 7'd0);
        cyc("R3", 1, 7'd0, 2'b10, 32'hCCCC_7788, 0, 7'd0, 7'd0);
        cyc("R3", 1, 7'd3, 2'b01, 32'h0000_9900, 0, 7'd0, 7'd0);
        cyc("R3", 0, 0, 0, 0, 0, 7'd0, 7'd3);

        // R4: word rows reject partial sizes
        cyc("R4", 1, 7'd4, 2'b11, 32'h4444_4444, 0, 7'd4, 7'd4);
        cyc("R4", 1, 7'd4, 2'b10, 32'h0000_FFFF, 0, 7'd4, 7'd4);
        cyc("R4", 1, 7'd6, 2'b00, 32'h0000_00FF, 0, 7'd4, 7'd6);
        cyc("R4", 1, 7'd5, 2'b01, 32'h0000_FF00, 0, 7'd4, 7'd5);
        cyc("R4", 0, 0, 0, 0, 0, 7'd6, 7'd5);

        // R5: half rows reject byte sizes, accept half and word
        cyc("R5", 1, 7'd7, 2'b11, 32'h7777_7777, 0, 7'd7, 7'd7);
        cyc("R5", 1, 7'd7, 2'b00, 32'h0000_0011, 0, 7'd7, 7'd7);
        cyc("R5", 1, 7'd7, 2'b01, 32'h0000_2200, 0, 7'd7, 7'd7);
        cyc("R5", 1, 7'd7, 2'b10, 32'hFFFF_ABCD, 0, 7'd7, 7'd7);
        cyc("R5", 1, 7'd10, 2'b11, 32'hA0A0_1010, 0, 7'd7, 7'd7);
        cyc("R5", 0, 0, 0, 0, 0, 7'd7, 7'd10);

        // R6: shadow row copy and width rule
        cyc("R6", 0, 0, 0, 0, 1, 7'd11, 7'd10);
        cyc("R6", 1, 7'd10, 2'b11, 32'h5555_AAAA, 1, 7'd11, 7'd10);
        cyc("R6", 1, 7'd11, 2'b10, 32'h0000_1234, 0, 7'd11, 7'd10);
        cyc("R6", 0, 0, 0, 0, 1, 7'd11, 7'd10);
        cyc("R6", 0, 0, 0, 0, 0, 7'd11, 7'd10);

        // R7: port write beats copy; rejected write lets copy through
        cyc("R7", 1, 7'd10, 2'b11, 32'h0BAD_F00D, 0, 7'd11, 7'd10);
        cyc("R7", 1, 7'd11, 2'b11, 32'h600D_0007, 1, 7'd11, 7'd10);
        cyc("R7", 1, 7'd11, 2'b10, 32'h0000_9999, 1, 7'd11, 7'd10);
        cyc("R7", 0, 0, 0, 0, 0, 7'd11, 7'd10);

        // R8: port B hides the shadow row
        cyc("R8", 0, 0, 0, 0, 0, 7'd11, 7'd11);

        // R9: constant and unmapped selectors
        cyc("R9", 0, 0, 0, 0, 0, 7'h7F, 7'h45);
        cyc("R9", 0, 0, 0, 0, 0, 7'd12, 7'h40);
        cyc("R9", 0, 0, 0, 0, 0, 7'h3F, 7'h7E);

        // R10: error only with request; out-of-range targets rejected
        cyc("R10", 0, 7'd4, 2'b00, 32'hFFFF_FFFF, 0, 7'd4, 7'd0);
        cyc("R10", 1, 7'h40, 2'b11, 32'hFFFF_FFFF, 0, 7'd0, 7'd1);
        cyc("R10", 1, 7'd12, 2'b11, 32'hFFFF_FFFF, 0, 7'd0, 7'd12);

        // R2: mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [6:0] ws, ra, rb;
            ws = ($urandom_range(0, 15) == 0) ? 7'h41 : 7'($urandom_range(0, 12));
            ra = ($urandom_range(0, 9) == 0) ? 7'h7F : 7'($urandom_range(0, 13));
            rb = 7'($urandom_range(0, 13));
            cyc("R2", 1'($urandom_range(0, 1)), ws, 2'($urandom_range(0, 3)),
                $urandom, 1'($urandom_range(0, 3) == 0), ra, rb);
        end

        // R1: reset mid-run clears state and drops the pending write
        do_reset();
        for (int i = 0; i < NR; i++) cyc("R1", 0, 0, 0, 0, 0, 7'(i), 7'(i));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule